// File: doc/BRIEF.md
# Vectored Interrupt Responder

This block sits on the peripheral side of a prioritised interrupt bus. A local event pulse marks a request as pending. The request is then shown on the one interrupt-request line that matches a level held in a control register. When the processor side raises the acknowledge line for that level, the block answers in one of two ways. It can return an 8-bit vector on the low data byte together with a transfer acknowledge. In autovector mode it instead raises the valid-peripheral-address strobe and leaves the data byte undriven.

Software loads two registers through a small write port: the vector number and a control word that holds the level and the mode. If no vector has been loaded since reset, the block returns the fixed code 0x0F, so the processor takes its uninitialised-vector path.

A bus guard runs beside the responder. It counts the clocks of every acknowledge cycle that this block has not terminated. When the count reaches its limit it raises bus error, which turns a cycle that nobody answers into a spurious interrupt.

Top module: `irq_vec_responder`

## Requirements
- R1: After a synchronous reset, irq_lines, dtack, vpa, berr, data_oe and data_out are all zero, and the vector counts as not yet loaded.
- R2: A write with reg_addr=0 loads the vector from reg_wdata[7:0]. A write with reg_addr=1 loads the level from reg_wdata[2:0] and the autovector mode from reg_wdata[3]. While the level is 0, evt_pulse has no effect: no request becomes pending, even after a nonzero level is written later.
- R3: An evt_pulse sampled at a clock edge, with level L in 1..7, sets irq_lines to the one-hot value with only bit L-1 high after that edge. The line stays high until the request is acknowledged.
- R4: When iack_lines[L-1] is sampled high while a request is pending, then after that edge (not in autovector mode) dtack=1, data_oe=1 and data_out holds the vector, and the request line is cleared at the same edge.
- R5: If the vector has never been written since reset, the acknowledged data byte is 0x0F.
- R6: In autovector mode an acknowledge raises vpa instead of dtack. data_oe stays 0 and data_out stays 0.
- R7: An acknowledge line of another level, or the own line while nothing is pending, gets no response (dtack, vpa and data_oe stay 0), and a pending request stays pending.
- R8: data_oe falls in the same cycle that the matching acknowledge line falls. data_out is zero whenever data_oe is 0.
- R9: dtack and vpa are cleared at the first clock edge at which the acknowledge line being answered is sampled low.
- R10: While any acknowledge line is high and this block has not answered, berr rises at the BERR_TIMEOUT-th edge (default 16) counted from the first edge with the line sampled high. berr holds until all acknowledge lines are low and clears at the next edge. An answered cycle never raises berr.
- R11: An evt_pulse at the same edge that starts an acknowledge leaves the request pending, so the request line stays high after that acknowledge.
- R12: dtack and vpa are never high together, and at most one request line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 selects the vector, 1 selects the control word |
| reg_wdata | input | 8 | Write data |
| evt_pulse | input | 1 | Event that requests an interrupt |
| iack_lines | input | NUM_LEVELS | Acknowledge lines, bit L-1 for level L |
| irq_lines | output | NUM_LEVELS | Request lines, bit L-1 for level L |
| data_out | output | 8 | Vector byte, zero when not driven |
| data_oe | output | 1 | Enable for the data byte |
| dtack | output | 1 | Transfer acknowledge |
| vpa | output | 1 | Autovector strobe |
| berr | output | 1 | Bus error from the acknowledge guard |

## Verification
A wrong pending flag shows up on irq_lines one edge after the event or after the acknowledge. It also shows as a missing or unwanted dtack one edge after an acknowledge line is raised. A stale latched level or a stuck responding state leaves dtack or vpa high past the single release edge, or lets data_oe outlive its acknowledge line within the same cycle. A wrong guard count moves the rise of berr away from edge 16 exactly, so the bench samples on both sides of that edge.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int VEC_W = 8;
  localparam logic [VEC_W-1:0] UNINIT_VEC = 8'h0F;
  localparam logic SEL_VEC  = 1'b0;
  localparam logic SEL_CTRL = 1'b1;
endpackage

// File: rtl/irqv_regs.sv
module irqv_regs #(
  parameter int VEC_W = 8,
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [VEC_W-1:0] wr_data,
  output logic [VEC_W-1:0] vec_eff,
  output logic [LVL_W-1:0] level,
  output logic             auto_mode
);
  import irqv_pkg::*;

  logic [VEC_W-1:0] vec_q;
  logic             vec_loaded_q;
  logic [LVL_W-1:0] level_q;
  logic             auto_q;
  logic             unused_hi;

  assign unused_hi = ^wr_data[VEC_W-1:LVL_W+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q        <= '0;
      vec_loaded_q <= 1'b0;
      level_q      <= '0;
      auto_q       <= 1'b0;
    end else if (wr_en) begin
      if (wr_addr == SEL_VEC) begin
        vec_q        <= wr_data;
        vec_loaded_q <= 1'b1;
      end else begin
        level_q <= wr_data[LVL_W-1:0];
        auto_q  <= wr_data[LVL_W];
      end
    end
  end

  assign vec_eff   = vec_loaded_q ? vec_q : UNINIT_VEC;
  assign level     = level_q;
  assign auto_mode = auto_q;
endmodule

// File: rtl/irqv_ack.sv
module irqv_ack #(
  parameter int NUM_LEVELS = 7,
  parameter int LVL_W      = 3,
  parameter int VEC_W      = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  evt,
  input  logic [LVL_W-1:0]      level,
  input  logic                  auto_mode,
  input  logic [VEC_W-1:0]      vec_eff,
  input  logic [NUM_LEVELS-1:0] iack_lines,
  output logic [NUM_LEVELS-1:0] irq_lines,
  output logic                  dtack,
  output logic                  vpa,
  output logic                  data_oe,
  output logic [VEC_W-1:0]      data_out
);
  logic [NUM_LEVELS-1:0] level_mask;
  logic [NUM_LEVELS-1:0] busy_mask_q;
  logic                  pending_q, busy_q, dtack_q, vpa_q, drive_q;
  logic [VEC_W-1:0]      vec_hold_q;
  logic                  lvl_ok, iack_hit, iack_held, ack_start;

  for (genvar i = 0; i < NUM_LEVELS; i++) begin : g_mask
    assign level_mask[i] = (level == LVL_W'(i + 1));
  end

  assign lvl_ok    = |level_mask;
  assign iack_hit  = |(iack_lines & level_mask);
  assign iack_held = |(iack_lines & busy_mask_q);
  assign ack_start = pending_q && iack_hit && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending_q   <= 1'b0;
      busy_q      <= 1'b0;
      busy_mask_q <= '0;
      dtack_q     <= 1'b0;
      vpa_q       <= 1'b0;
      drive_q     <= 1'b0;
      vec_hold_q  <= '0;
    end else begin
      pending_q <= (evt && lvl_ok) || (pending_q && !ack_start);
      if (ack_start) begin
        busy_q      <= 1'b1;
        busy_mask_q <= level_mask;
        dtack_q     <= !auto_mode;
        vpa_q       <= auto_mode;
        drive_q     <= !auto_mode;
        vec_hold_q  <= vec_eff;
      end else if (busy_q && !iack_held) begin
        busy_q      <= 1'b0;
        busy_mask_q <= '0;
        dtack_q     <= 1'b0;
        vpa_q       <= 1'b0;
        drive_q     <= 1'b0;
      end
    end
  end

  assign irq_lines = pending_q ? level_mask : '0;
  assign dtack     = dtack_q;
  assign vpa       = vpa_q;
  assign data_oe   = drive_q && iack_held;
  assign data_out  = data_oe ? vec_hold_q : '0;
endmodule

// File: rtl/irqv_busguard.sv
module irqv_busguard #(
  parameter int NUM_LEVELS = 7,
  parameter int TIMEOUT    = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_LEVELS-1:0] iack_lines,
  input  logic                  dtack,
  input  logic                  vpa,
  output logic                  berr
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             answered_q, berr_q, in_cycle;

  assign in_cycle = |iack_lines;

  always_ff @(posedge clk) begin
    if (rst || !in_cycle) begin
      cnt_q      <= '0;
      answered_q <= 1'b0;
      berr_q     <= 1'b0;
    end else begin
      if (dtack || vpa) answered_q <= 1'b1;
      if (!answered_q && !dtack && !vpa && !berr_q) begin
        if (cnt_q == CNT_W'(TIMEOUT - 1)) berr_q <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign berr = berr_q;
endmodule

// File: rtl/irq_vec_responder.sv
module irq_vec_responder #(
  parameter int NUM_LEVELS   = 7,
  parameter int BERR_TIMEOUT = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reg_wr_en,
  input  logic                  reg_addr,
  input  logic [7:0]            reg_wdata,
  input  logic                  evt_pulse,
  input  logic [NUM_LEVELS-1:0] iack_lines,
  output logic [NUM_LEVELS-1:0] irq_lines,
  output logic [7:0]            data_out,
  output logic                  data_oe,
  output logic                  dtack,
  output logic                  vpa,
  output logic                  berr
);
  localparam int LVL_W = $clog2(NUM_LEVELS + 1);
  localparam int VEC_W = irqv_pkg::VEC_W;

  logic [VEC_W-1:0] vec_eff;
  logic [LVL_W-1:0] level;
  logic             auto_mode;

  irqv_regs #(.VEC_W(VEC_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .wr_addr(reg_addr),
    .wr_data(reg_wdata), .vec_eff(vec_eff), .level(level),
    .auto_mode(auto_mode)
  );

  irqv_ack #(.NUM_LEVELS(NUM_LEVELS), .LVL_W(LVL_W), .VEC_W(VEC_W)) u_ack (
    .clk(clk), .rst(rst), .evt(evt_pulse), .level(level),
    .auto_mode(auto_mode), .vec_eff(vec_eff), .iack_lines(iack_lines),
    .irq_lines(irq_lines), .dtack(dtack), .vpa(vpa),
    .data_oe(data_oe), .data_out(data_out)
  );

  irqv_busguard #(.NUM_LEVELS(NUM_LEVELS), .TIMEOUT(BERR_TIMEOUT)) u_guard (
    .clk(clk), .rst(rst), .iack_lines(iack_lines), .dtack(dtack),
    .vpa(vpa), .berr(berr)
  );
endmodule

// File: rtl/irqv_responder_chk.sv
module irqv_responder_chk #(
  parameter int NUM_LEVELS = 7
) (
  input logic                  clk,
  input logic                  rst,
  input logic [NUM_LEVELS-1:0] iack_lines,
  input logic [NUM_LEVELS-1:0] irq_lines,
  input logic [7:0]            data_out,
  input logic                  data_oe,
  input logic                  dtack,
  input logic                  vpa,
  input logic                  berr
);
  p_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(dtack && vpa));
  p_irq_onehot_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_lines));
  p_oe_needs_iack_r8: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (|iack_lines));
  p_quiet_bus_r8: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == 8'h00));
  p_release_r9: assert property (@(posedge clk) disable iff (rst)
    !(|iack_lines) |=> (!dtack && !vpa));
  p_berr_release_r10: assert property (@(posedge clk) disable iff (rst)
    !(|iack_lines) |=> !berr);
  p_auto_nodata_r6: assert property (@(posedge clk) disable iff (rst)
    vpa |-> !data_oe);
  p_dtack_after_iack_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(dtack) |-> $past(|iack_lines));
endmodule

bind irq_vec_responder irqv_responder_chk #(.NUM_LEVELS(NUM_LEVELS)) u_chk (.*);

// File: tb/irq_vec_responder_bench.sv
`timescale 1ns/1ps
module irq_vec_responder_bench;
  localparam int NL = 7;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_wr_en = 1'b0;
  logic          reg_addr = 1'b0;
  logic [7:0]    reg_wdata = '0;
  logic          evt_pulse = 1'b0;
  logic [NL-1:0] iack_lines = '0;
  logic [NL-1:0] irq_lines;
  logic [7:0]    data_out;
  logic          data_oe, dtack, vpa, berr;
  int            checks = 0;
  int            errors = 0;

  always #2.5 clk = ~clk;

  irq_vec_responder #(.NUM_LEVELS(NL), .BERR_TIMEOUT(16)) u_irq_vec_responder (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_pulse(evt_pulse), .iack_lines(iack_lines),
    .irq_lines(irq_lines), .data_out(data_out), .data_oe(data_oe),
    .dtack(dtack), .vpa(vpa), .berr(berr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic a, input logic [7:0] d);
    @(negedge clk); reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr_en = 1'b0;
  endtask

  task automatic fire_evt();
    @(negedge clk); evt_pulse = 1'b1;
    @(negedge clk); evt_pulse = 1'b0;
  endtask

  task automatic release_iack();
    @(negedge clk); iack_lines = '0;
    #0.5;
    chk("R8 oe drops with iack", {31'd0, data_oe}, 32'd0);
    chk("R8 data zero", {24'd0, data_out}, 32'd0);
    @(negedge clk);
    chk("R9 dtack released", {31'd0, dtack}, 32'd0);
    chk("R9 vpa released", {31'd0, vpa}, 32'd0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 irq", {25'd0, irq_lines}, 32'd0);
    chk("R1 dtack/vpa/berr/oe", {28'd0, dtack, vpa, berr, data_oe}, 32'd0);
    chk("R1 data", {24'd0, data_out}, 32'd0);
  endtask

  task automatic t_uninit_vector();
    wr_reg(1'b1, 8'h02);
    fire_evt();
    chk("R3 irq level 2", {25'd0, irq_lines}, 32'h02);
    repeat (3) @(negedge clk);
    chk("R3 irq held", {25'd0, irq_lines}, 32'h02);
    iack_lines = 7'b0000010;
    @(negedge clk);
    chk("R4 dtack", {31'd0, dtack}, 32'd1);
    chk("R4 data_oe", {31'd0, data_oe}, 32'd1);
    chk("R5 uninit vector", {24'd0, data_out}, 32'h0F);
    chk("R4 irq cleared", {25'd0, irq_lines}, 32'd0);
    chk("R12 no vpa", {31'd0, vpa}, 32'd0);
    release_iack();
    chk("R10 answered no berr", {31'd0, berr}, 32'd0);
  endtask

  task automatic t_vectored();
    wr_reg(1'b0, 8'hA5);
    wr_reg(1'b1, 8'h05);
    fire_evt();
    chk("R3 irq level 5", {25'd0, irq_lines}, 32'h10);
    iack_lines = 7'b0010000;
    @(negedge clk);
    chk("R4 vector A5", {24'd0, data_out}, 32'hA5);
    chk("R4 dtack", {31'd0, dtack}, 32'd1);
    repeat (20) @(negedge clk);
    chk("R10 answered cycle no berr", {31'd0, berr}, 32'd0);
    release_iack();
  endtask

  task automatic t_level_zero();
    wr_reg(1'b1, 8'h00);
    fire_evt();
    chk("R2 level 0 ignores evt", {25'd0, irq_lines}, 32'd0);
    wr_reg(1'b1, 8'h03);
    @(negedge clk);
    chk("R2 no latent request", {25'd0, irq_lines}, 32'd0);
  endtask

  task automatic t_autovector();
    wr_reg(1'b1, 8'h0B);
    fire_evt();
    chk("R3 irq level 3", {25'd0, irq_lines}, 32'h04);
    iack_lines = 7'b0000100;
    @(negedge clk);
    chk("R6 vpa", {31'd0, vpa}, 32'd1);
    chk("R6 no dtack", {31'd0, dtack}, 32'd0);
    chk("R6 no oe", {31'd0, data_oe}, 32'd0);
    chk("R6 data zero", {24'd0, data_out}, 32'd0);
    release_iack();
  endtask

  task automatic t_mismatch_timeout();
    wr_reg(1'b1, 8'h03);
    fire_evt();
    iack_lines = 7'b0100000;
    repeat (15) @(posedge clk);
    @(negedge clk);
    chk("R7 no dtack", {31'd0, dtack}, 32'd0);
    chk("R7 no oe", {31'd0, data_oe}, 32'd0);
    chk("R7 still pending", {25'd0, irq_lines}, 32'h04);
    chk("R10 berr not before 16", {31'd0, berr}, 32'd0);
    @(negedge clk);
    chk("R10 berr at 16", {31'd0, berr}, 32'd1);
    repeat (3) @(negedge clk);
    chk("R10 berr held", {31'd0, berr}, 32'd1);
    iack_lines = '0;
    @(negedge clk);
    chk("R10 berr cleared", {31'd0, berr}, 32'd0);
    iack_lines = 7'b0000100;
    @(negedge clk);
    chk("R4 late ack", {31'd0, dtack}, 32'd1);
    release_iack();
    iack_lines = 7'b0000100;
    repeat (3) @(negedge clk);
    chk("R7 idle own level no dtack", {31'd0, dtack}, 32'd0);
    iack_lines = '0;
    @(negedge clk);
  endtask

  task automatic t_coincident_event();
    wr_reg(1'b1, 8'h01);
    fire_evt();
    @(negedge clk); iack_lines = 7'b0000001; evt_pulse = 1'b1;
    @(negedge clk); evt_pulse = 1'b0;
    chk("R11 dtack", {31'd0, dtack}, 32'd1);
    chk("R11 re-armed", {25'd0, irq_lines}, 32'h01);
    release_iack();
    iack_lines = 7'b0000001;
    @(negedge clk);
    chk("R11 second ack", {25'd0, irq_lines}, 32'd0);
    release_iack();
  endtask

  initial begin
    #1_000_000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_uninit_vector();
    t_vectored();
    t_level_zero();
    t_autovector();
    t_mismatch_timeout();
    t_coincident_event();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule